// File: doc/BRIEF.md
# Serial Channel Command and Mode Front End

This block is the control front end of one channel in a two-channel asynchronous serial controller. A byte-wide register bus writes a command register and a mode window. The block keeps the character format: word length, parity and stop bits. It also keeps the FIFO options and the baud-set choice, and it holds the receive and transmit enable state. It sends single-cycle reset strobes and the break request to the serial engines next to it. It assembles the channel status byte from the live readiness signals of those engines and from sticky error flags. The parameter `CHAN_ID` selects which channel's address block the instance answers.

Each channel occupies an eight-byte block whose base is the channel number shifted left by three. Within that block the offsets are fixed:
- offset 0 is the mode window;
- offset 1 reads the status byte;
- offset 2 is the command register;
- offset 3 holds the data registers, which live outside this block.

Three mode registers share offset 0. An internal pointer decides which of them an access reaches. The pointer state machine has three states: `PTR_MR0`, `PTR_MR1` and `PTR_MR2`.
- The "point to MR1" command moves the pointer to `PTR_MR1`.
- The "point to MR0" command moves it to `PTR_MR0`.
- Each read or write of the window advances it along MR0 → MR1 → MR2.
- In `PTR_MR2` the pointer stays where it is.

The break state machine has two states, `BRK_IDLE` and `BRK_SEND`. It moves from idle to send on the start-break command. It returns to idle on the stop-break command or on the transmitter reset command.

Top module: `uart_chan_ctl`

## Requirements
- R1: After reset both directions are disabled, break is idle, all mode registers are zero (word_bits 5, par_en 1, stop_two 0, fifo_ext 0, tx_half 0, baud_set 0) and the pointer is on MR1, so the first window write lands in MR1 and the next in MR2.
- R2: Command bits 0 and 1 enable and disable the receiver; bits 2 and 3 enable and disable the transmitter. A write that sets both bits of one direction leaves that direction disabled.
- R3: Command upper nibble 0x1 sets the pointer to MR1. Successive window writes go to MR1, then MR2, and then keep going to MR2.
- R4: Command upper nibble 0xB sets the pointer to MR0. The window access after an MR0 access reaches MR1.
- R5: A read of the window returns the register under the pointer, zero-extended, and advances the pointer like a write does.
- R6: MR1 bits [1:0] give 5, 6, 7 or 8 data bits on word_bits. MR1 bit 4 set means no parity (par_en 0). Otherwise bit 2 picks odd (1) or even (0) parity, so code 0 is even, 1 is odd and 4 is none.
- R7: stop_two is 1 only when the low nibble of MR2 is 0xF. The value 0x7 gives one stop bit.
- R8: MR0 bit 3 drives fifo_ext, bit 4 drives tx_half and bits [2:0] drive baud_set.
- R9: Upper nibble codes 0x2, 0x3, 0x4 and 0x5 each raise only their own strobe (rx_rst_p, tx_rst_p, err_rst_p, brk_rst_p). The strobe is high for exactly the one cycle after the write.
- R10: Code 0x6 raises brk_tx and code 0x7 drops it. Code 0x3 (transmitter reset) also drops it.
- R11: The status byte at offset 1 carries rx_ready in bit 0, rx_full in bit 1, tx_ready in bit 2 and tx_empty in bit 3, all live. It carries sticky overrun, parity, framing and break flags in bits 4 to 7, taken from err_ev[0] to err_ev[3].
- R12: Code 0x4 clears status bits 4 to 7 at the edge of its write and leaves bits 0 to 3 unchanged. An error event in that same cycle stays set.
- R13: Accesses whose channel bits (address bits above bit 2) differ from CHAN_ID change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address: channel bits above bit 2, offset below |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| rx_ready | input | 1 | Receiver holds a character |
| rx_full | input | 1 | Receive FIFO full |
| tx_ready | input | 1 | Transmitter can accept a character |
| tx_empty | input | 1 | Transmitter fully drained |
| err_ev | input | 4 | Error event pulses: overrun, parity, framing, break |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| rx_rst_p | output | 1 | Receiver reset strobe |
| tx_rst_p | output | 1 | Transmitter reset strobe |
| err_rst_p | output | 1 | Error status reset strobe |
| brk_rst_p | output | 1 | Break-change flag reset strobe |
| brk_tx | output | 1 | Transmit break level |
| word_bits | output | 4 | Data bits per character (5 to 8) |
| par_en | output | 1 | Parity enabled |
| par_odd | output | 1 | Odd parity when enabled |
| stop_two | output | 1 | Two stop bits |
| fifo_ext | output | 1 | Extended FIFO enabled |
| tx_half | output | 1 | Half-level transmit threshold |
| baud_set | output | 3 | Baud table selection |

## Verification
Two actions can fall on the same clock edge: a write of the error-reset command and a new error event from the receive engine. The bench asserts one err_ev bit during exactly the cycle in which the 0x40 command write is on the bus. It then reads the status byte. The older sticky flags must be gone, the new flag must remain and the live bits must be unchanged. A second same-cycle case is a command byte that sets both the enable and disable bit of one direction, which must leave that direction disabled.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    typedef enum logic [1:0] {
        PTR_MR0 = 2'd0,
        PTR_MR1 = 2'd1,
        PTR_MR2 = 2'd2
    } mr_ptr_e;

    typedef enum logic {
        BRK_IDLE = 1'b0,
        BRK_SEND = 1'b1
    } brk_state_e;

    localparam logic [3:0] OP_PTR_MR1 = 4'h1;
    localparam logic [3:0] OP_RX_RST  = 4'h2;
    localparam logic [3:0] OP_TX_RST  = 4'h3;
    localparam logic [3:0] OP_ERR_RST = 4'h4;
    localparam logic [3:0] OP_BRK_RST = 4'h5;
    localparam logic [3:0] OP_BRK_ON  = 4'h6;
    localparam logic [3:0] OP_BRK_OFF = 4'h7;
    localparam logic [3:0] OP_PTR_MR0 = 4'hB;

    localparam logic [2:0] OFS_MODE = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CMD  = 3'd2;

    typedef struct packed {
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic ptr_mr1;
        logic ptr_mr0;
        logic rx_rst;
        logic tx_rst;
        logic err_rst;
        logic brk_rst;
        logic brk_on;
        logic brk_off;
    } cmd_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_chan_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CHAN_ID = 0,
    parameter int DW      = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output cmd_t              cmd,
    output logic              win_wr,
    output logic              win_rd,
    output logic              stat_rd
);
    localparam int CHAN_W = ADDR_W - 3;

    logic       sel;
    logic [2:0] ofs;
    logic       cmd_wr;
    logic [3:0] op;

    assign sel    = (bus_addr[ADDR_W-1:3] == CHAN_W'(CHAN_ID));
    assign ofs    = bus_addr[2:0];
    assign cmd_wr = sel && bus_wr && (ofs == OFS_CMD);
    assign op     = bus_wdata[7:4];

    assign win_wr  = sel && bus_wr && (ofs == OFS_MODE);
    assign win_rd  = sel && bus_rd && (ofs == OFS_MODE);
    assign stat_rd = sel && bus_rd && (ofs == OFS_STAT);

    always_comb begin
        cmd         = '0;
        cmd.rx_on   = cmd_wr && bus_wdata[0];
        cmd.rx_off  = cmd_wr && bus_wdata[1];
        cmd.tx_on   = cmd_wr && bus_wdata[2];
        cmd.tx_off  = cmd_wr && bus_wdata[3];
        if (cmd_wr) begin
            unique case (op)
                OP_PTR_MR1: cmd.ptr_mr1 = 1'b1;
                OP_PTR_MR0: cmd.ptr_mr0 = 1'b1;
                OP_RX_RST:  cmd.rx_rst  = 1'b1;
                OP_TX_RST:  cmd.tx_rst  = 1'b1;
                OP_ERR_RST: cmd.err_rst = 1'b1;
                OP_BRK_RST: cmd.brk_rst = 1'b1;
                OP_BRK_ON:  cmd.brk_on  = 1'b1;
                OP_BRK_OFF: cmd.brk_off = 1'b1;
                default:    cmd.ptr_mr1 = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
    import uart_chan_pkg::*;
#(
    parameter int MR0_W = 5,
    parameter int MR1_W = 5,
    parameter int MR2_W = 4,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_mr1_cmd,
    input  logic             ptr_mr0_cmd,
    input  logic             win_wr,
    input  logic             win_rd,
    input  logic [MR0_W-1:0] wdata,
    output logic [MR0_W-1:0] mr0,
    output logic [MR1_W-1:0] mr1,
    output logic [MR2_W-1:0] mr2,
    output logic [DW-1:0]    win_rdata
);
    mr_ptr_e ptr_q, ptr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= PTR_MR1;
        else        ptr_q <= ptr_d;
    end

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_mr0_cmd) begin
            ptr_d = PTR_MR0;
        end else if (ptr_mr1_cmd) begin
            ptr_d = PTR_MR1;
        end else if (win_wr || win_rd) begin
            unique case (ptr_q)
                PTR_MR0: ptr_d = PTR_MR1;
                PTR_MR1: ptr_d = PTR_MR2;
                PTR_MR2: ptr_d = PTR_MR2;
                default: ptr_d = PTR_MR1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr0 <= '0;
            mr1 <= '0;
            mr2 <= '0;
        end else if (win_wr) begin
            unique case (ptr_q)
                PTR_MR0: mr0 <= wdata[MR0_W-1:0];
                PTR_MR1: mr1 <= wdata[MR1_W-1:0];
                PTR_MR2: mr2 <= wdata[MR2_W-1:0];
                default: mr1 <= mr1;
            endcase
        end
    end

    always_comb begin
        win_rdata = '0;
        unique case (ptr_q)
            PTR_MR0: win_rdata = DW'(mr0);
            PTR_MR1: win_rdata = DW'(mr1);
            PTR_MR2: win_rdata = DW'(mr2);
            default: win_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_ctl_fsm.sv
module uart_ctl_fsm
    import uart_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd,
    output logic rx_en,
    output logic tx_en,
    output logic rx_rst_p,
    output logic tx_rst_p,
    output logic err_rst_p,
    output logic brk_rst_p,
    output logic brk_tx
);
    brk_state_e brk_q, brk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) brk_q <= BRK_IDLE;
        else        brk_q <= brk_d;
    end

    always_comb begin
        brk_d = brk_q;
        unique case (brk_q)
            BRK_IDLE: if (cmd.brk_on) brk_d = BRK_SEND;
            BRK_SEND: if (cmd.brk_off || cmd.tx_rst) brk_d = BRK_IDLE;
            default:  brk_d = BRK_IDLE;
        endcase
    end

    assign brk_tx = (brk_q == BRK_SEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en     <= 1'b0;
            tx_en     <= 1'b0;
            rx_rst_p  <= 1'b0;
            tx_rst_p  <= 1'b0;
            err_rst_p <= 1'b0;
            brk_rst_p <= 1'b0;
        end else begin
            if (cmd.rx_off)     rx_en <= 1'b0;
            else if (cmd.rx_on) rx_en <= 1'b1;
            if (cmd.tx_off)     tx_en <= 1'b0;
            else if (cmd.tx_on) tx_en <= 1'b1;
            rx_rst_p  <= cmd.rx_rst;
            tx_rst_p  <= cmd.tx_rst;
            err_rst_p <= cmd.err_rst;
            brk_rst_p <= cmd.brk_rst;
        end
    end
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg #(
    parameter int ERR_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_ready,
    input  logic             rx_full,
    input  logic             tx_ready,
    input  logic             tx_empty,
    input  logic [ERR_N-1:0] err_ev,
    input  logic             err_clr,
    output logic [ERR_N+3:0] stat_byte
);
    logic [ERR_N-1:0] sticky_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (err_clr ? '0 : sticky_q) | err_ev;
    end

    assign stat_byte = {sticky_q, tx_empty, tx_ready, rx_full, rx_ready};
endmodule

// File: rtl/uart_chan_ctl.sv
module uart_chan_ctl
    import uart_chan_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_ready,
    input  logic              rx_full,
    input  logic              tx_ready,
    input  logic              tx_empty,
    input  logic [3:0]        err_ev,
    output logic              rx_en,
    output logic              tx_en,
    output logic              rx_rst_p,
    output logic              tx_rst_p,
    output logic              err_rst_p,
    output logic              brk_rst_p,
    output logic              brk_tx,
    output logic [3:0]        word_bits,
    output logic              par_en,
    output logic              par_odd,
    output logic              stop_two,
    output logic              fifo_ext,
    output logic              tx_half,
    output logic [2:0]        baud_set
);
    localparam int DW    = 8;
    localparam int MR0_W = 5;
    localparam int MR1_W = 5;
    localparam int MR2_W = 4;

    cmd_t             cmd;
    logic             win_wr, win_rd, stat_rd;
    logic [MR0_W-1:0] mr0;
    logic [MR1_W-1:0] mr1;
    logic [MR2_W-1:0] mr2;
    logic [DW-1:0]    win_rdata;
    logic [DW-1:0]    stat_byte;

    uart_cmd_decode #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID), .DW(DW)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .cmd      (cmd),
        .win_wr   (win_wr),
        .win_rd   (win_rd),
        .stat_rd  (stat_rd)
    );

    uart_mode_regs #(.MR0_W(MR0_W), .MR1_W(MR1_W), .MR2_W(MR2_W), .DW(DW)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_mr1_cmd(cmd.ptr_mr1),
        .ptr_mr0_cmd(cmd.ptr_mr0),
        .win_wr     (win_wr),
        .win_rd     (win_rd),
        .wdata      (bus_wdata[MR0_W-1:0]),
        .mr0        (mr0),
        .mr1        (mr1),
        .mr2        (mr2),
        .win_rdata  (win_rdata)
    );

    uart_ctl_fsm u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .rx_en    (rx_en),
        .tx_en    (tx_en),
        .rx_rst_p (rx_rst_p),
        .tx_rst_p (tx_rst_p),
        .err_rst_p(err_rst_p),
        .brk_rst_p(brk_rst_p),
        .brk_tx   (brk_tx)
    );

    uart_stat_reg #(.ERR_N(4)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_ready (rx_ready),
        .rx_full  (rx_full),
        .tx_ready (tx_ready),
        .tx_empty (tx_empty),
        .err_ev   (err_ev),
        .err_clr  (cmd.err_rst),
        .stat_byte(stat_byte)
    );

    assign bus_rdata = win_rd  ? win_rdata :
                       stat_rd ? stat_byte : '0;

    assign word_bits = 4'd5 + {2'b00, mr1[1:0]};
    assign par_en    = ~mr1[4];
    assign par_odd   = mr1[2];
    assign stop_two  = (mr2 == 4'hF);
    assign fifo_ext  = mr0[3];
    assign tx_half   = mr0[4];
    assign baud_set  = mr0[2:0];
endmodule

// File: rtl/uart_chan_ctl_chk.sv
module uart_chan_ctl_chk #(
    parameter int ADDR_W  = 4,
    parameter int CHAN_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [3:0]        err_ev,
    input logic              rx_en,
    input logic              tx_en,
    input logic              rx_rst_p,
    input logic              tx_rst_p,
    input logic              brk_tx,
    input logic [3:0]        err_bits
);
    localparam int CHAN_W = ADDR_W - 3;

    logic cmd_hit, foreign_wr;
    assign cmd_hit    = bus_wr && (bus_addr == {CHAN_W'(CHAN_ID), 3'd2});
    assign foreign_wr = bus_wr && (bus_addr[ADDR_W-1:3] != CHAN_W'(CHAN_ID));

    // R2
    rx_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && bus_wdata[1]) |=> !rx_en);

    // R2
    tx_off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && bus_wdata[3]) |=> !tx_en);

    // R9
    rx_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst_p |-> $past(cmd_hit && bus_wdata[7:4] == 4'h2));

    // R10
    brk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst_p |-> !brk_tx);

    // R12
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && bus_wdata[7:4] == 4'h4 && err_ev == 4'h0) |=> (err_bits == 4'h0));

    // R13
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        foreign_wr |=> ($stable(rx_en) && $stable(tx_en) && $stable(brk_tx)));
endmodule

bind uart_chan_ctl uart_chan_ctl_chk #(.ADDR_W(ADDR_W), .CHAN_ID(CHAN_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .err_ev   (err_ev),
    .rx_en    (rx_en),
    .tx_en    (tx_en),
    .rx_rst_p (rx_rst_p),
    .tx_rst_p (tx_rst_p),
    .brk_tx   (brk_tx),
    .err_bits (stat_byte[7:4])
);

// File: tb/uart_chan_ctl_bench.sv
module uart_chan_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_ready = 1'b0, rx_full = 1'b0, tx_ready = 1'b0, tx_empty = 1'b0;
    logic [3:0] err_ev = '0;
    logic       rx_en, tx_en, rx_rst_p, tx_rst_p, err_rst_p, brk_rst_p, brk_tx;
    logic [3:0] word_bits;
    logic       par_en, par_odd, stop_two, fifo_ext, tx_half;
    logic [2:0] baud_set;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_chan_ctl u_uart_chan_ctl (.*);

    // {MR1 byte, expected word_bits, par_en, par_odd}
    localparam int NV = 8;
    localparam logic [13:0] VEC [NV] = '{
        {8'h00, 4'd5, 1'b1, 1'b0},
        {8'h01, 4'd6, 1'b1, 1'b0},
        {8'h06, 4'd7, 1'b1, 1'b1},
        {8'h07, 4'd8, 1'b1, 1'b1},
        {8'h13, 4'd8, 1'b0, 1'b0},
        {8'h12, 4'd7, 1'b0, 1'b0},
        {8'h05, 4'd6, 1'b1, 1'b1},
        {8'h10, 4'd5, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulses(input string tag, input logic [3:0] exp);
        chk(tag, {rx_rst_p, tx_rst_p, err_rst_p, brk_rst_p}, exp);
        @(negedge clk);
        chk({tag, " drop"}, {rx_rst_p, tx_rst_p, err_rst_p, brk_rst_p}, 4'h0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 enables", {rx_en, tx_en, brk_tx}, 3'b000);
        chk("R1 format", {word_bits, par_en, par_odd, stop_two}, {4'd5, 3'b100});
        chk("R1 mr0", {fifo_ext, tx_half, baud_set}, 5'h00);
        rd(4'h1, d);
        chk("R1 status", d, 8'h00);
        wr(4'h0, 8'h03);
        chk("R1 pointer starts on MR1", word_bits, 4'd8);
        wr(4'h0, 8'h0F);
        chk("R7 two stop bits", stop_two, 1'b1);

        // R6 vector table
        for (int i = 0; i < NV; i++) begin
            wr(4'h2, 8'h10);
            wr(4'h0, VEC[i][13:6]);
            chk($sformatf("R6 vec %0d", i), {word_bits, par_en, par_odd}, VEC[i][5:0]);
        end

        // R3 pointer walk stays on MR2
        wr(4'h2, 8'h10);
        wr(4'h0, 8'h07);
        wr(4'h0, 8'h0F);
        chk("R3 second write to MR2", {word_bits, stop_two}, {4'd8, 1'b1});
        wr(4'h0, 8'h07);
        chk("R3 stays on MR2", {word_bits, stop_two}, {4'd8, 1'b0});

        // R4 / R8 MR0 pointer
        wr(4'h2, 8'hB0);
        wr(4'h0, 8'h1D);
        chk("R8 mr0 fields", {fifo_ext, tx_half, baud_set, word_bits}, {1'b1, 1'b1, 3'd5, 4'd8});
        wr(4'h0, 8'h02);
        chk("R4 MR0 then MR1", {word_bits, fifo_ext}, {4'd7, 1'b1});

        // R5 reads advance pointer
        wr(4'h2, 8'h10);
        rd(4'h0, d); chk("R5 read MR1", d, 8'h02);
        rd(4'h0, d); chk("R5 read MR2", d, 8'h07);
        rd(4'h0, d); chk("R5 read MR2 again", d, 8'h07);
        wr(4'h2, 8'hB0);
        rd(4'h0, d); chk("R5 read MR0", d, 8'h1D);
        rd(4'h0, d); chk("R5 read after MR0", d, 8'h02);

        // R2 enables
        wr(4'h2, 8'h05); chk("R2 both on", {rx_en, tx_en}, 2'b11);
        wr(4'h2, 8'h02); chk("R2 rx off", {rx_en, tx_en}, 2'b01);
        wr(4'h2, 8'h0C); chk("R2 tx on+off", {rx_en, tx_en}, 2'b00);
        wr(4'h2, 8'h01); chk("R2 rx on", {rx_en, tx_en}, 2'b10);
        wr(4'h2, 8'h03); chk("R2 rx on+off", rx_en, 1'b0);
        wr(4'h2, 8'h01);

        // R9 strobes
        wr(4'h2, 8'h20); pulses("R9 rx reset", 4'b1000);
        wr(4'h2, 8'h30); pulses("R9 tx reset", 4'b0100);
        wr(4'h2, 8'h40); pulses("R9 err reset", 4'b0010);
        wr(4'h2, 8'h50); pulses("R9 brk reset", 4'b0001);

        // R10 break
        wr(4'h2, 8'h60); chk("R10 start break", brk_tx, 1'b1);
        wr(4'h2, 8'h70); chk("R10 stop break", brk_tx, 1'b0);
        wr(4'h2, 8'h60);
        wr(4'h2, 8'h30); chk("R10 tx reset ends break", brk_tx, 1'b0);

        // R11 live bits
        @(negedge clk); rx_ready = 1'b1; tx_empty = 1'b1;
        rd(4'h1, d); chk("R11 status live", d, 8'h09);
        rx_full = 1'b1; tx_ready = 1'b1;
        rd(4'h1, d); chk("R11 status all live", d, 8'h0F);

        // R12 sticky errors and same-cycle clear
        @(negedge clk); err_ev = 4'b0101;
        @(negedge clk); err_ev = 4'b0000;
        rd(4'h1, d); chk("R11 sticky errors", d, 8'h5F);
        wr(4'h2, 8'h40);
        rd(4'h1, d); chk("R12 clear keeps ready", d, 8'h0F);
        @(negedge clk); err_ev = 4'b0011;
        @(negedge clk); err_ev = 4'b0000;
        @(negedge clk);
        bus_addr = 4'h2; bus_wdata = 8'h40; bus_wr = 1'b1; err_ev = 4'b1000;
        @(negedge clk);
        bus_wr = 1'b0; err_ev = 4'b0000;
        rd(4'h1, d); chk("R12 event during clear kept", d, 8'h8F);

        // R13 other channel ignored
        wr(4'hA, 8'h0E); chk("R13 foreign command", {rx_en, tx_en}, 2'b10);
        wr(4'hA, 8'h60); chk("R13 foreign break", brk_tx, 1'b0);
        wr(4'hA, 8'h10);
        wr(4'h8, 8'h03); chk("R13 foreign window", word_bits, 4'd7);
        rd(4'h9, d); chk("R13 foreign read", d, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule